// File: doc/BRIEF.md
# PLL Frequency Lock Detector

This block decides whether a PLL's divided feedback clock runs at the same frequency as its reference clock. Each clock arrives as a one-cycle event pulse that has already been synchronized into the system clock domain. A reference counter measures out count windows, and a feedback counter records how many feedback events fall inside each window. When the window's final reference event arrives, the two counts are compared against a tolerance.

To avoid false lock from frequency aliasing, window lengths alternate between `N_CYC` and `N_CYC + K_CYC` reference events. Lock is declared only after a short window and then a long window both match under the tight tolerance `TOL_T`. Once locked, the tolerance widens to `2*TOL_T`, which gives hysteresis, and the alternating windows keep running. A single failed comparison while locked drops lock, emits a one-cycle loss pulse, restores the tight tolerance and restarts acquisition. An external-clock-mode input disables the PLL, and no lock is ever reported while it is high. A synchronous restart input forces the idle acquisition state.

Top module: `pll_lock_detect`

## Requirements
- R1: After reset, `locked` and `lock_lost` are 0, the tight tolerance applies, and the first window is `N_CYC` reference events long.
- R2: A window ends on the cycle that carries its final reference event. A feedback event in that same cycle counts toward the ending window. Both counts restart from zero for the next window.
- R3: While unlocked, a short window whose feedback count f satisfies |f − N_CYC| ≤ TOL_T makes the next window `N_CYC+K_CYC` long. Otherwise the next window is `N_CYC` long again.
- R4: `locked` rises one clock after the final reference event of a long window that matches under the tight tolerance and directly follows a matching short window.
- R5: While unlocked, a long window that fails the tight check leaves the block unlocked, and the next window is `N_CYC` long.
- R6: While locked, window lengths alternate, starting with `N_CYC` right after lock is declared.
- R7: While locked, a window matches when |f − L| ≤ 2*TOL_T, where L is that window's length.
- R8: A failed comparison while locked clears `locked` and pulses `lock_lost` high for exactly one cycle, both one clock after the final reference event. The next window is `N_CYC` long under the tight tolerance.
- R9: While `ext_mode` is 1, `locked` is 0 from the next clock on, both counters are held at zero, and `lock_lost` stays 0. Acquisition starts again with a short window after `ext_mode` returns to 0.
- R10: `restart` at 1 forces the post-reset state on the next clock, including when the block is locked, and never pulses `lock_lost`.
- R11: The feedback counter saturates instead of wrapping, so an excess of feedback events never appears as a match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| restart | input | 1 | Synchronous return to the unlocked, tight-tolerance start state |
| ext_mode | input | 1 | External clock mode; PLL treated as disabled |
| ref_tick | input | 1 | One-cycle pulse per reference clock edge |
| fb_tick | input | 1 | One-cycle pulse per feedback clock edge |
| locked | output | 1 | Frequency lock detected |
| lock_lost | output | 1 | One-cycle pulse when a comparison drops lock |

## Verification
The bench builds the block with N_CYC=4, K_CYC=2 and TOL_T=1, so a long window is 6 events, the relaxed band is ±2 and the feedback counter is 5 bits wide. With these values every feedback count from 0 to three above the window length can be swept for both the short and long acquisition windows. Every offset from −3 to +3 can also be swept in both window phases while locked. A run of 36 feedback events exceeds the 5-bit counter, so a wrapping counter would show up as a spurious match and a lock at the wrong time.

// File: rtl/lkd_pkg.sv
package lkd_pkg;
  typedef enum logic [1:0] {
    ST_HUNT    = 2'd0,
    ST_CONFIRM = 2'd1,
    ST_LOCKED  = 2'd2
  } lkd_state_e;
endpackage

// File: rtl/lkd_ref_window.sv
module lkd_ref_window #(
  parameter int N_CYC = 4,
  parameter int K_CYC = 2,
  parameter int W     = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic long_win,
  input  logic ref_tick,
  output logic win_end
);
  localparam logic [W-1:0] LEN_S = W'(N_CYC);
  localparam logic [W-1:0] LEN_L = W'(N_CYC + K_CYC);

  logic [W-1:0] cnt_q;
  logic [W-1:0] win_len;

  assign win_len = long_win ? LEN_L : LEN_S;
  assign win_end = ref_tick && !clear && (cnt_q == win_len - W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt_q <= '0;
    else if (clear || win_end) cnt_q <= '0;
    else if (ref_tick)         cnt_q <= cnt_q + W'(1);
  end

  AST_REF_BELOW_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < win_len); // R2
endmodule

// File: rtl/lkd_fb_count.sv
module lkd_fb_count #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         win_end,
  input  logic         fb_tick,
  output logic [W-1:0] fb_total
);
  localparam logic [W-1:0] CMAX = '1;

  logic [W-1:0] cnt_q;

  assign fb_total = (fb_tick && cnt_q != CMAX) ? cnt_q + W'(1) : cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt_q <= '0;
    else if (clear || win_end) cnt_q <= '0;
    else                       cnt_q <= fb_total;
  end

  AST_FB_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CMAX && !clear && !win_end) |=> cnt_q == CMAX); // R11
endmodule

// File: rtl/lkd_tol_cmp.sv
module lkd_tol_cmp #(
  parameter int N_CYC = 4,
  parameter int K_CYC = 2,
  parameter int TOL_T = 1,
  parameter int W     = 5
) (
  input  logic         long_win,
  input  logic         relaxed,
  input  logic [W-1:0] fb_total,
  output logic         match
);
  localparam logic [W-1:0] LEN_S = W'(N_CYC);
  localparam logic [W-1:0] LEN_L = W'(N_CYC + K_CYC);
  localparam logic [W-1:0] TOL_N = W'(TOL_T);
  localparam logic [W-1:0] TOL_R = W'(2 * TOL_T);

  logic [W-1:0] ref_len;
  logic [W-1:0] diff;

  always_comb begin
    ref_len = long_win ? LEN_L : LEN_S;
    diff    = (fb_total >= ref_len) ? fb_total - ref_len : ref_len - fb_total;
    match   = diff <= (relaxed ? TOL_R : TOL_N);
  end
endmodule

// File: rtl/pll_lock_detect.sv
module pll_lock_detect #(
  parameter int N_CYC = 4,
  parameter int K_CYC = 2,
  parameter int TOL_T = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic ext_mode,
  input  logic ref_tick,
  input  logic fb_tick,
  output logic locked,
  output logic lock_lost
);
  import lkd_pkg::*;

  localparam int CNT_W = $clog2(N_CYC + K_CYC + 2 * TOL_T + 2) + 1;

  lkd_state_e       st_q;
  logic             long_q;
  logic             lost_q;
  logic             hold;
  logic             win_end;
  logic             match;
  logic [CNT_W-1:0] fb_total;

  assign hold = restart || ext_mode;

  lkd_ref_window #(.N_CYC(N_CYC), .K_CYC(K_CYC), .W(CNT_W)) u_ref (
    .clk(clk), .rst_n(rst_n), .clear(hold), .long_win(long_q),
    .ref_tick(ref_tick), .win_end(win_end)
  );

  lkd_fb_count #(.W(CNT_W)) u_fb (
    .clk(clk), .rst_n(rst_n), .clear(hold), .win_end(win_end),
    .fb_tick(fb_tick), .fb_total(fb_total)
  );

  lkd_tol_cmp #(.N_CYC(N_CYC), .K_CYC(K_CYC), .TOL_T(TOL_T), .W(CNT_W)) u_cmp (
    .long_win(long_q), .relaxed(st_q == ST_LOCKED),
    .fb_total(fb_total), .match(match)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_HUNT;
      long_q <= 1'b0;
      lost_q <= 1'b0;
    end else if (hold) begin
      st_q   <= ST_HUNT;
      long_q <= 1'b0;
      lost_q <= 1'b0;
    end else begin
      lost_q <= 1'b0;
      if (win_end) begin
        case (st_q)
          ST_HUNT: begin
            if (match) begin
              st_q   <= ST_CONFIRM;
              long_q <= 1'b1;
            end else begin
              long_q <= 1'b0;
            end
          end
          ST_CONFIRM: begin
            st_q   <= match ? ST_LOCKED : ST_HUNT;
            long_q <= 1'b0;
          end
          ST_LOCKED: begin
            if (match) begin
              long_q <= ~long_q;
            end else begin
              st_q   <= ST_HUNT;
              long_q <= 1'b0;
              lost_q <= 1'b1;
            end
          end
          default: begin
            st_q   <= ST_HUNT;
            long_q <= 1'b0;
          end
        endcase
      end
    end
  end

  assign locked    = (st_q == ST_LOCKED);
  assign lock_lost = lost_q;

  AST_LOST_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    lock_lost |=> !lock_lost); // R8
  AST_LOST_FROM_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    lock_lost |-> (!locked && $past(locked))); // R8
  AST_HOLD_UNLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> (!locked && !lock_lost)); // R9
  AST_LOCK_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(win_end && long_q && match)); // R4
endmodule

// File: tb/pll_lock_detect_test.sv
`timescale 1ns/1ps
module pll_lock_detect_test;
  localparam int N = 4;
  localparam int K = 2;
  localparam int T = 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic restart = 1'b0;
  logic ext_mode = 1'b0;
  logic ref_tick = 1'b0;
  logic fb_tick = 1'b0;
  logic locked, lock_lost;

  int vectors = 0;
  int fails = 0;
  bit done = 0;

  int exp_st = 0;
  bit exp_long = 0;
  bit exp_lost = 0;

  always #4 clk = ~clk;

  pll_lock_detect #(.N_CYC(N), .K_CYC(K), .TOL_T(T)) uut (
    .clk(clk), .rst_n(rst_n), .restart(restart), .ext_mode(ext_mode),
    .ref_tick(ref_tick), .fb_tick(fb_tick), .locked(locked), .lock_lost(lock_lost)
  );

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  task automatic model_reset();
    exp_st = 0; exp_long = 0; exp_lost = 0;
  endtask

  task automatic run_window(input int f, input string req);
    int len = exp_long ? N + K : N;
    int span = (f > len) ? f : len;
    int d;
    bit m;
    for (int c = 0; c < span; c++) begin
      @(negedge clk);
      ref_tick = (c >= span - len);
      fb_tick  = (c < f);
    end
    @(negedge clk);
    ref_tick = 0; fb_tick = 0;
    exp_lost = 0;
    if (!ext_mode) begin
      d = f - len;
      if (d < 0) d = -d;
      m = d <= ((exp_st == 2) ? 2 * T : T);
      case (exp_st)
        0: if (m) begin exp_st = 1; exp_long = 1; end else exp_long = 0;
        1: begin exp_st = m ? 2 : 0; exp_long = 0; end
        default: if (m) exp_long = !exp_long;
                 else begin exp_st = 0; exp_long = 0; exp_lost = 1; end
      endcase
    end
    chk(req, "locked", locked, exp_st == 2);
    chk(req, "lock_lost", lock_lost, exp_lost);
  endtask

  task automatic do_restart();
    @(negedge clk); restart = 1;
    @(negedge clk); restart = 0;
    model_reset();
    chk("R10", "locked after restart", locked, 1'b0);
    chk("R10", "lost after restart", lock_lost, 1'b0);
  endtask

  task automatic acquire();
    run_window(N, "R3");
    run_window(N + K, "R4");
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "locked in reset", locked, 1'b0);
    chk("R1", "lost in reset", lock_lost, 1'b0);
    rst_n = 1;
    @(negedge clk);
    chk("R1", "locked after reset", locked, 1'b0);

    // R3 R4 R5: sweep both acquisition windows
    for (int f0 = 0; f0 <= N + 3; f0++) begin
      for (int f1 = 0; f1 <= N + K + 3; f1++) begin
        do_restart();
        run_window(f0, "R3");
        if (exp_st == 1) run_window(f1, "R5");
        run_window(N, "R2");
      end
    end

    // R6 R7 R8: relaxed band in both locked phases
    for (int ph = 0; ph < 2; ph++) begin
      for (int d = -3; d <= 3; d++) begin
        do_restart();
        acquire();
        if (ph == 1) run_window(N, "R6");
        run_window((exp_long ? N + K : N) + d, "R7");
        if (exp_lost) begin
          @(negedge clk);
          chk("R8", "lost pulse width", lock_lost, 1'b0);
          run_window(N + 2 * T, "R8");
          acquire();
        end
      end
    end

    // R9: external clock mode
    do_restart();
    acquire();
    chk("R9", "locked before ext", locked, 1'b1);
    @(negedge clk); ext_mode = 1;
    @(negedge clk);
    model_reset();
    chk("R9", "locked in ext", locked, 1'b0);
    chk("R9", "lost in ext", lock_lost, 1'b0);
    run_window(N, "R9");
    run_window(N + K, "R9");
    @(negedge clk); ext_mode = 0;
    acquire();
    chk("R9", "relock after ext", locked, 1'b1);

    // R10: restart while locked
    do_restart();
    acquire();
    do_restart();
    run_window(N + K, "R10");

    // R11: feedback surplus beyond counter range
    do_restart();
    run_window(36, "R11");
    acquire();

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule